// File: doc/BRIEF.md
# Iterative 32-bit Feistel Block Encryptor

This core encrypts a single 32-bit block under a 64-bit key with a lightweight Feistel network of 32 rounds. Each round uses only word rotations, bitwise AND and bitwise XOR on two 16-bit halves. The round keys are derived on the fly from a four-word sliding window. The window is seeded with the master key and advanced by a nonlinear-free recurrence mixed with a fixed 62-bit constant sequence. The core has no key expansion memory.

A build-time parameter `R`, a power of two from 1 to 32, sets how many rounds are chained combinationally within one clock. A smaller `R` gives fewer gates and more cycles per block. A larger `R` gives a deeper cone and fewer cycles. The iteration counter narrows as `R` grows, to log2(32/R) bits with a floor of one bit. The host pulses `start` with the plaintext and key present. It then waits for `done` and reads `ciphertext`, which holds until the next accepted start. Only one block is in flight at a time.

Top module: `simon_iter_core`

## Requirements
- R1: `plaintext[31:16]` is the left word and `plaintext[15:0]` is the right word. `key[16q+15:16q]` is key word q, and word 0 is the first round key. When `done` is high, `ciphertext` is {left, right} after 32 rounds. Key 0x1918111009080100 with plaintext 0x65656877 gives 0xc69be9bb.
- R2: Each round computes new_left = right ^ ((left rotl 1) & (left rotl 8)) ^ (left rotl 2) ^ k, and new_right = left.
- R3: The round key for round i+4 is k[i] ^ t ^ 0xFFFC ^ z[i]. Here t = u ^ (u rotr 1), u = (k[i+3] rotr 3) ^ k[i+1], and z is the bit sequence 11111010001001010110000111001101111101000100101011000011100110, read from its first character.
- R4: Let e0 be the clock edge that accepts `start`. Then `done` first reads high after edge e0 + 32/R, so one block occupies 32/R + 2 cycles counting the load cycle and the output cycle.
- R5: `busy` is high from the edge after an accepted start until `done` rises, and `busy` and `done` are never high together. A `start` seen while `busy` is high is ignored and does not change the result or the latency.
- R6: `done` stays high and `ciphertext` stays unchanged until the next `start`. A `start` while idle or done clears `done` at the next edge and begins a new block.
- R7: After reset, `busy` and `done` are low.
- R8: Every allowed value of `R` (1, 2, 4, 8, 16, 32) produces the same ciphertext for the same inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a block; accepted only when not busy |
| plaintext | input | 32 | Input block, left word in the upper half |
| key | input | 64 | Master key, key word 0 in the lowest 16 bits |
| busy | output | 1 | Rounds are being computed |
| done | output | 1 | Ciphertext valid and held |
| ciphertext | output | 32 | Encrypted block, left word in the upper half |

## Verification
The properties assume that `rst_n` is low at time zero and that `start` is a clean synchronous level. They also assume that `plaintext` and `key` matter only in the cycle where a start is accepted, so nothing is required of them during a block. The stimulus drives every input on the falling edge. It changes `plaintext` and `key` only together with a start pulse. The one deliberate violation of the idle handshake is a start raised one cycle into a block, which the design must ignore. Six instances, one for each value of `R`, receive identical stimulus. Each result is compared against a software recurrence that is written independently of the RTL.

// File: rtl/simon_pkg.sv
package simon_pkg;
  localparam int WORD_W = 16;
  localparam int KEY_WORDS = 4;
  localparam int NUM_ROUNDS = 32;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [KEY_WORDS-1:0][WORD_W-1:0] kwin_t;

  // constant sequence, element 0 leftmost
  localparam logic [0:61] ZSEQ =
    62'b11111010001001010110000111001101111101000100101011000011100110;

  function automatic word_t rotl(input word_t w, input int s);
    return (w << s) | (w >> (WORD_W - s));
  endfunction

  function automatic word_t rotr(input word_t w, input int s);
    return (w >> s) | (w << (WORD_W - s));
  endfunction

  // nonlinear mixing of the left word
  function automatic word_t mix_f(input word_t l);
    return (rotl(l, 1) & rotl(l, 8)) ^ rotl(l, 2);
  endfunction

  // next key word from window entries 0, 1, 3 and one sequence bit
  function automatic word_t key_step(input word_t k0, input word_t k1,
                                     input word_t k3, input logic zb);
    word_t u;
    u = rotr(k3, 3) ^ k1;
    u = u ^ rotr(u, 1);
    return k0 ^ u ^ 16'hFFFC ^ {15'd0, zb};
  endfunction
endpackage

// File: rtl/simon_round_step.sv
module simon_round_step
  import simon_pkg::*;
(
  input  word_t l_i,
  input  word_t r_i,
  input  kwin_t kw_i,
  input  logic  zb_i,
  output word_t l_o,
  output word_t r_o,
  output kwin_t kw_o
);
  // round key is the oldest window entry
  assign l_o = r_i ^ mix_f(l_i) ^ kw_i[0];
  assign r_o = l_i;

  // slide window by one word
  assign kw_o[KEY_WORDS-2:0] = kw_i[KEY_WORDS-1:1];
  assign kw_o[KEY_WORDS-1]   = key_step(kw_i[0], kw_i[1], kw_i[3], zb_i);
endmodule

// File: rtl/simon_unrolled.sv
module simon_unrolled
  import simon_pkg::*;
#(
  parameter int R = 1
) (
  input  logic [5:0] base_i,
  input  word_t      l_i,
  input  word_t      r_i,
  input  kwin_t      kw_i,
  output word_t      l_o,
  output word_t      r_o,
  output kwin_t      kw_o
);
  word_t ls [R+1];
  word_t rs [R+1];
  kwin_t ks [R+1];
  logic  zb [R];

  assign ls[0] = l_i;
  assign rs[0] = r_i;
  assign ks[0] = kw_i;

  for (genvar j = 0; j < R; j++) begin : g_rnd
    assign zb[j] = ZSEQ[base_i + 6'(j)];
    simon_round_step u_step (
      .l_i (ls[j]),
      .r_i (rs[j]),
      .kw_i(ks[j]),
      .zb_i(zb[j]),
      .l_o (ls[j+1]),
      .r_o (rs[j+1]),
      .kw_o(ks[j+1])
    );
  end

  assign l_o  = ls[R];
  assign r_o  = rs[R];
  assign kw_o = ks[R];
endmodule

// File: rtl/simon_ctrl.sv
module simon_ctrl #(
  parameter int ITERS = 32,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          load,
  output logic          fin,
  output logic [CW-1:0] iter
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} st_t;
  st_t st_q;

  assign busy = (st_q == ST_RUN);
  assign done = (st_q == ST_DONE);
  assign load = start & ~busy;
  assign fin  = busy & (iter == CW'(ITERS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      iter <= '0;
    end else if (load) begin
      st_q <= ST_RUN;
      iter <= '0;
    end else if (fin) begin
      st_q <= ST_DONE;
    end else if (busy) begin
      iter <= iter + CW'(1);
    end
  end
endmodule

// File: rtl/simon_iter_core.sv
module simon_iter_core
  import simon_pkg::*;
#(
  parameter int R = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] plaintext,
  input  logic [63:0] key,
  output logic        busy,
  output logic        done,
  output logic [31:0] ciphertext
);
  localparam int ITERS = NUM_ROUNDS / R;
  localparam int CW    = (ITERS > 1) ? $clog2(ITERS) : 1;

  // named internal events
  logic          load;
  logic          fin;
  logic [CW-1:0] iter;
  logic [5:0]    base;

  word_t l_q, r_q, l_n, r_n;
  kwin_t kw_q, kw_n;

  simon_ctrl #(.ITERS(ITERS), .CW(CW)) u_ctrl (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .busy (busy),
    .done (done),
    .load (load),
    .fin  (fin),
    .iter (iter)
  );

  // index of the first round handled this cycle
  assign base = 6'(iter) * 6'(R);

  simon_unrolled #(.R(R)) u_dp (
    .base_i(base),
    .l_i   (l_q),
    .r_i   (r_q),
    .kw_i  (kw_q),
    .l_o   (l_n),
    .r_o   (r_n),
    .kw_o  (kw_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_q  <= '0;
      r_q  <= '0;
      kw_q <= '0;
    end else if (load) begin
      l_q  <= plaintext[31:16];
      r_q  <= plaintext[15:0];
      kw_q <= key;
    end else if (busy) begin
      l_q  <= l_n;
      r_q  <= r_n;
      kw_q <= kw_n;
    end
  end

  assign ciphertext = {l_q, r_q};
endmodule

// File: rtl/simon_core_chk.sv
module simon_core_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          load,
  input logic          fin,
  input logic [CW-1:0] iter,
  input logic [31:0]   ciphertext
);
  // R7
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!busy && !done));

  // R5
  exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  // R5
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !fin) |=> busy);

  // R4
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin) |=> (iter == $past(iter) + CW'(1)));

  // R4
  fin_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> done);

  // R4
  done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(fin));

  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(ciphertext)));

  // R6
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (busy && !done));
endmodule

bind simon_iter_core simon_core_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .load      (load),
  .fin       (fin),
  .iter      (iter),
  .ciphertext(ciphertext)
);

// File: tb/sim_simon_iter_core.sv
module sim_simon_iter_core;
  localparam int NV = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] pt = '0;
  logic [63:0] ky = '0;
  logic [NV-1:0] busy_v, done_v;
  logic [31:0] ct_v [NV];

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int t0 = 0;
  bit pending = 1'b0;
  bit [NV-1:0] seen;
  logic [31:0] exp_q [$];
  logic [31:0] last_exp;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // one instance per allowed rounds-per-cycle value (R8)
  for (genvar g = 0; g < NV; g++) begin : g_dut
    simon_iter_core #(.R(1 << g)) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .plaintext (pt),
      .key       (ky),
      .busy      (busy_v[g]),
      .done      (done_v[g]),
      .ciphertext(ct_v[g])
    );
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // software model written from R1..R3
  function automatic logic [31:0] ref_enc(input logic [31:0] p, input logic [63:0] k);
    string zs = "11111010001001010110000111001101111101000100101011000011100110";
    logic [15:0] ks [0:31];
    logic [15:0] a, b, t;
    for (int q = 0; q < 4; q++) ks[q] = k[16*q +: 16];
    for (int i = 0; i < 28; i++) begin
      t = {ks[i+3][2:0], ks[i+3][15:3]} ^ ks[i+1];
      t = t ^ {t[0], t[15:1]};
      ks[i+4] = ~ks[i] ^ t ^ 16'd3 ^ {15'd0, (zs[i] == 8'h31)};
    end
    a = p[31:16];
    b = p[15:0];
    for (int i = 0; i < 32; i++) begin
      t = a;
      a = b ^ ({a[14:0], a[15]} & {a[7:0], a[15:8]}) ^ {a[13:0], a[15:14]} ^ ks[i];
      b = t;
    end
    return {a, b};
  endfunction

  // monitor: pop an expected item once every instance has reported
  always @(negedge clk) begin
    if (pending) begin
      for (int g = 0; g < NV; g++) begin
        if (done_v[g] && !seen[g]) begin
          seen[g] = 1'b1;
          // R1 R8 ciphertext
          chk(ct_v[g] == exp_q[0], $sformatf("R1/R8 ct R=%0d", 1 << g),
              64'(ct_v[g]), 64'(exp_q[0]));
          // R4 latency in edges after the accepting edge
          chk((cyc - t0) == (32 >> g), $sformatf("R4 latency R=%0d", 1 << g),
              64'(cyc - t0), 64'(32 >> g));
        end
      end
      if (&seen) begin
        last_exp = exp_q.pop_front();
        pending = 1'b0;
      end
    end
  end

  // driver; intr raises a second start one cycle into the block
  task automatic issue(input logic [31:0] p, input logic [63:0] k, input bit intr);
    @(negedge clk);
    pt = p;
    ky = k;
    start = 1'b1;
    @(posedge clk);
    #1;
    t0 = cyc;
    seen = '0;
    exp_q.push_back(ref_enc(p, k));
    pending = 1'b1;
    // R6 new start clears done, R5 busy follows
    chk(done_v == '0, "R6 done cleared on start", 64'(done_v), 64'(0));
    chk(busy_v == '1, "R5 busy after start", 64'(busy_v), 64'(6'h3f));
    @(negedge clk);
    if (intr) begin
      pt = ~p;
      ky = ~k;
      start = 1'b1;
      @(negedge clk);
    end
    start = 1'b0;
    while (pending) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R7 reset state
    chk(done_v == '0 && busy_v == '0, "R7 reset idle",
        64'({busy_v, done_v}), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(done_v == '0 && busy_v == '0, "R7 idle after release",
        64'({busy_v, done_v}), 64'(0));

    // R1 known vector, bench model against the published value
    chk(ref_enc(32'h65656877, 64'h1918111009080100) == 32'hc69be9bb, "R1 model vector",
        64'(ref_enc(32'h65656877, 64'h1918111009080100)), 64'(32'hc69be9bb));
    issue(32'h65656877, 64'h1918111009080100, 1'b0);

    // R6 hold for several cycles without start
    repeat (10) @(negedge clk);
    for (int g = 0; g < NV; g++)
      chk(done_v[g] && ct_v[g] == last_exp, "R6 hold", 64'({done_v[g], ct_v[g]}),
          64'({1'b1, last_exp}));

    // R5 start while busy is ignored
    issue(32'h65656877, 64'h1918111009080100, 1'b1);
    for (int g = 0; g < NV; g++)
      chk(ct_v[g] == 32'hc69be9bb, "R5 ignored start", 64'(ct_v[g]), 64'(32'hc69be9bb));

    // R2 R3 corner patterns
    issue(32'h0000_0000, 64'h0, 1'b0);
    issue(32'hffff_ffff, 64'hffff_ffff_ffff_ffff, 1'b0);
    issue(32'h8000_0001, 64'h0001_0000_0000_8000, 1'b0);
    for (int n = 0; n < 8; n++)
      issue($urandom, {$urandom, $urandom}, n[0]);

    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule